// File: doc/BRIEF.md
# Condition Register Field Transfer Unit

This block keeps a 32-bit condition register split into eight 4-bit fields. Field 0 is the most significant nibble and field 7 the least significant. An opcode input selects one field-oriented operation. Three opcodes write the register: a masked load of many fields from a 64-bit source, a load of one field picked by a priority mask, and a copy of the overflow and carry flags into a named field.

The other opcodes are pure reads. They return a 64-bit integer computed from the register: one field in its natural place, the whole register zero-extended, a three-way compare encoding taken from a field, or a 0/1 or 0/-1 value taken from a single bit.

An execution pipeline uses the block by presenting one operation per cycle with a valid strobe. A read result is combinational in the same cycle. A write lands at the next rising clock edge. Bit numbering follows the MSB-first convention: condition bit k (0..31) is `cr_o[31-k]`, and mask bit n (0..7) is `mask_i[7-n]`.

Top module: `crx_unit`

## Requirements
- R1: After reset (`rst_n` low, asynchronous), `cr_o` is 0. While `valid_i` is low, `result_o` is 0.
- R2: Opcode 0 (masked load): for each n with `mask_i[7-n]`=1, field n takes `src_i[31-4n -: 4]`. Every other field keeps its value.
- R3: Opcode 1 (single load): only field n is written from `src_i[31-4n -: 4]`, where n is the smallest index with `mask_i[7-n]`=1.
- R4: Opcode 1 with `mask_i`=0 writes field 7 from `src_i[3:0]`.
- R5: Opcode 2 (single read): `result_o` is zero except bits `31-4n -: 4`, which hold field n, where n is the smallest index with a set mask bit. With `mask_i`=0, `result_o` is 0.
- R6: Opcode 3 (full read): `result_o` is 32 zero bits above `cr_o`.
- R7: Opcode 4 (flag copy): field `fld_i` becomes {`ov_i`,`ov32_i`,`ca_i`,`ca32_i`}, with `ov_i` in the field's most significant bit.
- R8: Opcode 5 (three-way): let F be field `fld_i`. If F[3]=1, the result is all ones. Otherwise, if F[2]=1, the result is 1. Otherwise the result is 0.
- R9: Opcodes 6 and 7: with b = condition bit `bit_i`, opcode 6 returns b and opcode 7 returns !b, both as 64-bit 0 or 1.
- R10: Opcodes 8 and 9: opcode 8 returns -1 when b is set and 0 otherwise. Opcode 9 returns 0 when b is set and -1 otherwise.
- R11: The register changes only on a rising edge with `valid_i`=1 and opcode 0, 1 or 4. Read opcodes and cycles with `valid_i`=0 leave it unchanged, and write opcodes return `result_o`=0.
- R12: Opcodes 10 to 15 return `result_o`=0 and leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode (see requirements) |
| mask_i | input | 8 | Field mask, bit 7 selects field 0 |
| fld_i | input | 3 | Field index for flag copy and three-way |
| bit_i | input | 5 | Condition bit index, 0 is the MSB |
| src_i | input | 64 | Source operand, low 32 bits used |
| ov_i | input | 1 | Overflow flag |
| ov32_i | input | 1 | 32-bit overflow flag |
| ca_i | input | 1 | Carry flag |
| ca32_i | input | 1 | 32-bit carry flag |
| result_o | output | 64 | Integer result of the current operation |
| cr_o | output | 32 | Condition register |

## Verification
The masked load is exercised with masks of zero, all ones, single bits and random patterns. These cases separate a correct per-field mapping from a reversed bit order or a nibble shifted by one. The single load and single read are driven with masks that have several bits set and with an all-zero mask, which exposes the wrong priority direction and the missing field 7 fallback. The three-way and single-bit operations run on random registers and on nibbles with both top bits set, which checks that all ones takes precedence over one. Unused opcodes and strobes held low are interleaved with writes, so any stray write shows in `cr_o`.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int NF   = 8;
  localparam int FW   = 4;
  localparam int CRW  = NF * FW;
  localparam int XLEN = 64;
  localparam int IW   = $clog2(NF);
  localparam int BW   = $clog2(CRW);

  typedef enum logic [3:0] {
    OP_WMASK   = 4'd0,
    OP_WONE    = 4'd1,
    OP_RONE    = 4'd2,
    OP_RALL    = 4'd3,
    OP_FLAGS   = 4'd4,
    OP_SETB    = 4'd5,
    OP_SETBC   = 4'd6,
    OP_SETBCR  = 4'd7,
    OP_SETNBC  = 4'd8,
    OP_SETNBCR = 4'd9
  } crx_op_e;

  function automatic logic [FW-1:0] fld_get(logic [CRW-1:0] cr, logic [IW-1:0] n);
    return cr[CRW-1-FW*int'(n) -: FW];
  endfunction

  function automatic logic [XLEN-1:0] fld_place(logic [FW-1:0] v, logic [IW-1:0] n);
    logic [XLEN-1:0] w;
    w = XLEN'(v);
    return w << (CRW - FW - FW*int'(n));
  endfunction

  function automatic logic bit_get(logic [CRW-1:0] cr, logic [BW-1:0] bi);
    return cr[CRW-1-int'(bi)];
  endfunction

  function automatic logic [XLEN-1:0] three_way(logic [FW-1:0] f);
    if (f[FW-1])      return '1;
    else if (f[FW-2]) return XLEN'(1);
    else              return '0;
  endfunction

  function automatic logic is_write(logic [3:0] op);
    return (op == OP_WMASK) || (op == OP_WONE) || (op == OP_FLAGS);
  endfunction
endpackage

// File: rtl/crx_prio.sv
module crx_prio
  import crx_pkg::*;
(
  input  logic [NF-1:0] mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = IW'(NF-1);
    any_o = 1'b0;
    for (int n = NF-1; n >= 0; n--) begin
      if (mask_i[NF-1-n]) begin
        idx_o = IW'(n);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/crx_wr.sv
module crx_wr
  import crx_pkg::*;
(
  input  logic [3:0]     op_i,
  input  logic [NF-1:0]  mask_i,
  input  logic [IW-1:0]  fld_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [FW-1:0]  flags_i,
  input  logic [IW-1:0]  sel_idx_i,
  input  logic [CRW-1:0] cr_i,
  output logic [CRW-1:0] cr_next_o
);
  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam int HI = CRW - 1 - FW*g;
    logic [FW-1:0] cur, src_f, nxt;
    assign cur   = cr_i[HI -: FW];
    assign src_f = src_i[HI -: FW];
    always_comb begin
      nxt = cur;
      unique case (op_i)
        OP_WMASK: if (mask_i[NF-1-g]) nxt = src_f;
        OP_WONE:  if (sel_idx_i == IW'(g)) nxt = src_f;
        OP_FLAGS: if (fld_i == IW'(g)) nxt = flags_i;
        default:  nxt = cur;
      endcase
    end
    assign cr_next_o[HI -: FW] = nxt;
  end
endmodule

// File: rtl/crx_rd.sv
module crx_rd
  import crx_pkg::*;
(
  input  logic           valid_i,
  input  logic [3:0]     op_i,
  input  logic [IW-1:0]  fld_i,
  input  logic [BW-1:0]  bit_i,
  input  logic [IW-1:0]  sel_idx_i,
  input  logic           sel_any_i,
  input  logic [CRW-1:0] cr_i,
  output logic [XLEN-1:0] result_o
);
  logic cbit;
  assign cbit = bit_get(cr_i, bit_i);

  always_comb begin
    result_o = '0;
    if (valid_i) begin
      unique case (op_i)
        OP_RONE:    result_o = sel_any_i ? fld_place(fld_get(cr_i, sel_idx_i), sel_idx_i) : '0;
        OP_RALL:    result_o = {{(XLEN-CRW){1'b0}}, cr_i};
        OP_SETB:    result_o = three_way(fld_get(cr_i, fld_i));
        OP_SETBC:   result_o = XLEN'(cbit);
        OP_SETBCR:  result_o = XLEN'(!cbit);
        OP_SETNBC:  result_o = cbit ? '1 : '0;
        OP_SETNBCR: result_o = cbit ? '0 : '1;
        default:    result_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/crx_unit.sv
module crx_unit
  import crx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [3:0]  op_i,
  input  logic [7:0]  mask_i,
  input  logic [2:0]  fld_i,
  input  logic [4:0]  bit_i,
  input  logic [63:0] src_i,
  input  logic        ov_i,
  input  logic        ov32_i,
  input  logic        ca_i,
  input  logic        ca32_i,
  output logic [63:0] result_o,
  output logic [31:0] cr_o
);
  logic [CRW-1:0] cr_q, cr_next;
  logic [IW-1:0]  sel_idx;
  logic           sel_any;
  logic           wr_en;
  logic [FW-1:0]  flags;

  assign flags = {ov_i, ov32_i, ca_i, ca32_i};
  assign wr_en = valid_i && is_write(op_i);

  crx_prio u_prio (
    .mask_i (mask_i),
    .idx_o  (sel_idx),
    .any_o  (sel_any)
  );

  crx_wr u_wr (
    .op_i      (op_i),
    .mask_i    (mask_i),
    .fld_i     (fld_i),
    .src_i     (src_i),
    .flags_i   (flags),
    .sel_idx_i (sel_idx),
    .cr_i      (cr_q),
    .cr_next_o (cr_next)
  );

  crx_rd u_rd (
    .valid_i   (valid_i),
    .op_i      (op_i),
    .fld_i     (fld_i),
    .bit_i     (bit_i),
    .sel_idx_i (sel_idx),
    .sel_any_i (sel_any),
    .cr_i      (cr_q),
    .result_o  (result_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cr_q <= '0;
    else if (wr_en) cr_q <= cr_next;
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/crx_chk.sv
module crx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [3:0]  op_i,
  input logic [63:0] result_o,
  input logic [31:0] cr_o,
  input logic [2:0]  sel_idx,
  input logic        sel_any,
  input logic        wr_en
);
  logic [2:0]  tgt;
  logic [31:0] keep;
  logic [7:0]  nz;
  assign tgt = sel_any ? sel_idx : 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep <= '0;
    else        keep <= ~(32'hF << (28 - 4*int'(tgt)));
  end

  always_comb
    for (int n = 0; n < 8; n++) nz[n] = |result_o[31-4*n -: 4];

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> cr_o == 32'd0);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cr_o));

  a_r11_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> result_o == 64'd0);

  a_r3_single_field: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd1) |=> ((cr_o ^ $past(cr_o)) & keep) == 32'd0);

  a_r5_read_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd2) |-> (result_o[63:32] == 32'd0 && $onehot0(nz)));

  a_r8_setb_range: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd5) |-> (result_o == 64'd0 || result_o == 64'd1 || &result_o));

  a_r9_bool_range: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 4'd6 || op_i == 4'd7)) |-> result_o[63:1] == 63'd0);

  a_r10_neg_range: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 4'd8 || op_i == 4'd9)) |-> ($countones(result_o) == 0 || $countones(result_o) == 64));
endmodule

bind crx_unit crx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .result_o (result_o),
  .cr_o     (cr_o),
  .sel_idx  (sel_idx),
  .sel_any  (sel_any),
  .wr_en    (wr_en)
);

// File: tb/sim_crx_unit.sv
`timescale 1ns/1ps
module sim_crx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  mask_i = '0;
  logic [2:0]  fld_i = '0;
  logic [4:0]  bit_i = '0;
  logic [63:0] src_i = '0;
  logic        ov_i = 0, ov32_i = 0, ca_i = 0, ca32_i = 0;
  logic [63:0] result_o;
  logic [31:0] cr_o;

  int tests = 0, fails = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  crx_unit u0 (.*);

  function automatic logic [3:0] nib(logic [31:0] c, int n);
    return 4'((c >> (4*(7-n))) & 32'hF);
  endfunction

  function automatic int first_fld(logic [7:0] m);
    for (int n = 0; n < 8; n++) if (m[7-n]) return n;
    return -1;
  endfunction

  function automatic logic [31:0] put_nib(logic [31:0] c, int n, logic [3:0] v);
    logic [31:0] sh;
    sh = 32'hF << (4*(7-n));
    return (c & ~sh) | ((32'(v) << (4*(7-n))) & sh);
  endfunction

  function automatic logic [63:0] exp_res(logic [31:0] c, logic v, logic [3:0] op,
      logic [7:0] m, logic [2:0] f, logic [4:0] bi);
    logic b; logic [3:0] q; int k;
    b = (c >> (31 - int'(bi))) & 1;
    if (!v) return 0;
    case (op)
      4'd2: begin k = first_fld(m); return (k < 0) ? 64'd0 : (64'(nib(c,k)) << (4*(7-k))); end
      4'd3: return 64'(c);
      4'd5: begin q = nib(c, int'(f)); return q[3] ? -64'sd1 : (q[2] ? 64'd1 : 64'd0); end
      4'd6: return b ? 64'd1 : 64'd0;
      4'd7: return b ? 64'd0 : 64'd1;
      4'd8: return b ? ~64'd0 : 64'd0;
      4'd9: return b ? 64'd0 : ~64'd0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_next(logic [31:0] c, logic v, logic [3:0] op,
      logic [7:0] m, logic [2:0] f, logic [31:0] s, logic [3:0] fl);
    logic [31:0] r; int k;
    r = c;
    if (!v) return r;
    case (op)
      4'd0: for (int n = 0; n < 8; n++) if (m[7-n]) r = put_nib(r, n, nib(s, n));
      4'd1: begin k = first_fld(m); if (k < 0) k = 7; r = put_nib(r, k, nib(s, k)); end
      4'd4: r = put_nib(r, int'(f), fl);
      default: r = c;
    endcase
    return r;
  endfunction

  function automatic string rtag(logic v, logic [3:0] op, logic [7:0] m);
    if (!v) return "R1";
    case (op)
      4'd2: return "R5";  4'd3: return "R6";  4'd5: return "R8";
      4'd6, 4'd7: return "R9";  4'd8, 4'd9: return "R10";
      4'd0, 4'd1, 4'd4: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic string wtag(logic v, logic [3:0] op, logic [7:0] m);
    if (!v) return "R11";
    case (op)
      4'd0: return "R2";
      4'd1: return (m == 0) ? "R4" : "R3";
      4'd4: return "R7";
      4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic run(logic v, logic [3:0] op, logic [7:0] m, logic [2:0] f,
      logic [4:0] bi, logic [63:0] s, logic [3:0] fl);
    logic [31:0] nx;
    @(negedge clk);
    valid_i = v; op_i = op; mask_i = m; fld_i = f; bit_i = bi; src_i = s;
    {ov_i, ov32_i, ca_i, ca32_i} = fl;
    #2;
    chk(rtag(v, op, m), result_o, exp_res(model, v, op, m, f, bi));
    nx = exp_next(model, v, op, m, f, s[31:0], fl);
    @(posedge clk); #2;
    model = nx;
    chk(wtag(v, op, m), 64'(cr_o), 64'(model));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2;
    chk("R1", 64'(cr_o), 64'd0);
    chk("R1", result_o, 64'd0);
    rst_n = 1'b1;
    // R2 directed masks
    run(1, 4'd0, 8'hFF, 0, 0, 64'hDEAD_BEEF_1234_5678, 0);
    run(1, 4'd0, 8'h81, 0, 0, 64'h0000_0000_ABCD_EF90, 0);
    run(1, 4'd0, 8'h00, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run(1, 4'd0, 8'h20, 0, 0, 64'h0000_0000_0F00_0000, 0);
    // R3 priority with several bits, R4 empty mask
    run(1, 4'd1, 8'h2C, 0, 0, 64'h0000_0000_9999_9999, 0);
    run(1, 4'd1, 8'h00, 0, 0, 64'h0000_0000_7777_7777, 0);
    run(1, 4'd1, 8'h01, 0, 0, 64'h0000_0000_0000_0003, 0);
    // R5 read with multi-bit and zero masks
    run(1, 4'd2, 8'h0A, 0, 0, 0, 0);
    run(1, 4'd2, 8'h00, 0, 0, 0, 0);
    run(1, 4'd3, 0, 0, 0, 0, 0);
    // R7 flag copy order
    run(1, 4'd4, 0, 3'd2, 0, 0, 4'b1000);
    run(1, 4'd4, 0, 3'd7, 0, 0, 4'b0001);
    // R8 with both top bits set, then second only
    run(1, 4'd0, 8'hC0, 0, 0, 64'h0000_0000_C400_0000, 0);
    run(1, 4'd5, 0, 3'd0, 0, 0, 0);
    run(1, 4'd5, 0, 3'd1, 0, 0, 0);
    run(1, 4'd5, 0, 3'd3, 0, 0, 0);
    // R9 R10 on bit 0 and bit 31
    for (int op = 6; op <= 9; op++) begin
      run(1, 4'(op), 0, 0, 5'd0, 0, 0);
      run(1, 4'(op), 0, 0, 5'd31, 0, 0);
    end
    // R11 strobe low with write op, R12 unknown opcode
    run(0, 4'd0, 8'hFF, 0, 0, 64'h1111_1111_1111_1111, 0);
    run(1, 4'd12, 8'hFF, 0, 0, 64'h2222_2222_2222_2222, 4'hF);
    for (int i = 0; i < 600; i++) begin
      run(($urandom_range(0, 7) != 0), 4'($urandom_range(0, 15)), 8'($urandom),
          3'($urandom), 5'($urandom), {$urandom, $urandom}, 4'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule